// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives up to four buck power stages from one shared period counter. Each active channel runs the same counter, shifted by an equal fraction of the period. The channels therefore take turns, and the ripple seen at the output repeats n times per channel period. A digital duty command sets the nominal pulse width. Each channel trims that command by how far its own sampled phase current sits from the mean current of all active channels. A channel carrying more than its share gets a narrower pulse, and a channel carrying less gets a wider one.

The number of channels is not programmed. Board straps tie unused outputs high, and the block reads back the level on output pins 3 and 4 in the first clock after reset is released. It holds the resulting channel count until the next reset. Each output is a level plus an output-enable, so the off (high-impedance) state is visible at the ports. Two global requests act on top of normal modulation: one releases every output to high impedance, and the other clamps the active outputs low.

Top module: `mphase_pwm`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, every `pwm_oe` and every `pwm_lvl` bit is 0.
- R2: In the first clock after reset release, the channel count n is decoded from `strap_sense` and latched. If both bits are 1, n = 2. If only bit 1 (output 4) is 1, n = 3. Otherwise n = 4. Channels 0..n-1 are active, so with no request pending `pwm_oe` reads 4'b0011, 4'b0111 or 4'b1111.
- R3: Inactive channels always show `pwm_oe` = 0 and `pwm_lvl` = 0. The latched count ignores later changes on `strap_sense` until the next reset.
- R4: After detection, a shared counter steps through 0..PERIOD-1 once per clock. The local count of channel k is (count - k*PERIOD/n) mod PERIOD, so the active channels lag one another by PERIOD/n clocks.
- R5: An active channel with no request pending drives `pwm_lvl` = 1 exactly while its local count is below its latched duty.
- R6: A channel captures its current sample when its local count equals (latched duty + PERIOD/3) mod PERIOD. This is one third of a period after its pulse ends.
- R7: The duty target of a channel is `duty_cmd` + floor((avg - sample) / 2^CORR_SHIFT). Here avg = floor(sum of the captured samples of the active channels / n).
- R8: The duty target is clamped to the range 0..PERIOD.
- R9: A channel loads its target into its latched duty only when its local count is PERIOD-1. The new width takes effect from local count 0.
- R10: While `tristate_req` = 1 and `force_low_req` = 0, every `pwm_oe` and every `pwm_lvl` is 0.
- R11: While `force_low_req` = 1, active channels show `pwm_oe` = 1 and `pwm_lvl` = 0, whatever `tristate_req` is. The counter, sampling and duty loading continue during either request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_cmd | input | DW | Nominal duty in clocks (0..2^DW-1) |
| isample | input | 4*IW | Phase-current codes; channel k in bits [k*IW +: IW] |
| strap_sense | input | 2 | Level read back from outputs 3 (bit 0) and 4 (bit 1) |
| tristate_req | input | 1 | Release all outputs to high impedance |
| force_low_req | input | 1 | Drive active outputs low |
| pwm_lvl | output | 4 | Output level per channel |
| pwm_oe | output | 4 | Output enable per channel |

## Verification
The hardest state to reach is one where current trim, saturation and the period-boundary load all interact. This happens when the mean shifts because another channel's sample was captured in the same period. The captured samples are never visible, so every effect must be observed through pulse widths one boundary later. The stimulus holds strongly unbalanced currents, with one channel far below the others, against command values beyond both ends of the range. This pushes the trimmed targets into both clamps. Random command changes are spread across all local counts, so loads at the boundary are exercised for 2, 3 and 4 channels. Each case is followed by a cycle-by-cycle reference model built from the requirements.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
    localparam int NCH = 4;
endpackage

// File: rtl/mpwm_phase_timer.sv
module mpwm_phase_timer
    import mpwm_pkg::*;
#(
    parameter int PERIOD = 24,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [2:0]               n_ch,
    output logic [NCH-1:0][CW-1:0]   lc
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (run) begin
            nxt_d.cnt = CW'((int'(cur_q.cnt) + 1) % PERIOD);
        end
        for (int k = 0; k < NCH; k++) begin
            int nn;
            int off;
            nn    = (n_ch == 3'd0) ? 1 : int'(n_ch);
            off   = (k * PERIOD) / nn;
            lc[k] = CW'((int'(cur_q.cnt) + PERIOD - (off % PERIOD)) % PERIOD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && int'(cur_q.cnt) == PERIOD - 1) |=> (cur_q.cnt == '0)); // R4
endmodule

// File: rtl/mpwm_trim.sv
module mpwm_trim
    import mpwm_pkg::*;
#(
    parameter int PERIOD     = 24,
    parameter int DW         = $clog2(PERIOD + 1),
    parameter int IW         = 8,
    parameter int CORR_SHIFT = 1
) (
    input  logic [2:0]               n_ch,
    input  logic [DW-1:0]            duty_cmd,
    input  logic [NCH-1:0][IW-1:0]   samp,
    output logic [NCH-1:0][DW-1:0]   duty_tgt
);
    always_comb begin
        int sum;
        int nn;
        int avg;
        sum = 0;
        nn  = (n_ch == 3'd0) ? 1 : int'(n_ch);
        for (int k = 0; k < NCH; k++) begin
            if (k < nn) sum = sum + int'(samp[k]);
        end
        avg = sum / nn;
        for (int k = 0; k < NCH; k++) begin
            int diff;
            int cand;
            diff = avg - int'(samp[k]);
            cand = int'(duty_cmd) + (diff >>> CORR_SHIFT);
            if (cand < 0)           cand = 0;
            else if (cand > PERIOD) cand = PERIOD;
            duty_tgt[k] = DW'(cand);
        end
    end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
    parameter int PERIOD = 24,
    parameter int CW     = $clog2(PERIOD),
    parameter int DW     = $clog2(PERIOD + 1),
    parameter int IW     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tristate,
    input  logic           force_low,
    input  logic [CW-1:0]  lc,
    input  logic [DW-1:0]  duty_tgt,
    input  logic [IW-1:0]  isample,
    output logic           lvl,
    output logic           oe,
    output logic [IW-1:0]  samp_out
);
    typedef struct packed {
        logic [DW-1:0] duty;
        logic [IW-1:0] samp;
    } ch_t;

    ch_t cur_q, nxt_d;

    always_comb begin
        int sp;
        nxt_d = cur_q;
        sp    = (int'(cur_q.duty) + PERIOD / 3) % PERIOD;
        if (run) begin
            if (int'(lc) == sp)         nxt_d.samp = isample;
            if (int'(lc) == PERIOD - 1) nxt_d.duty = duty_tgt;
        end
        oe       = run && (force_low || !tristate);
        lvl      = oe && !force_low && (int'(lc) < int'(cur_q.duty));
        samp_out = cur_q.samp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_DUTY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_q.duty) <= PERIOD); // R8
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lc) != PERIOD - 1) |=> $stable(cur_q.duty)); // R9
endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
    import mpwm_pkg::*;
#(
    parameter int PERIOD     = 24,
    parameter int IW         = 8,
    parameter int CORR_SHIFT = 1,
    localparam int CW        = $clog2(PERIOD),
    localparam int DW        = $clog2(PERIOD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       duty_cmd,
    input  logic [NCH*IW-1:0]   isample,
    input  logic [1:0]          strap_sense,
    input  logic                tristate_req,
    input  logic                force_low_req,
    output logic [NCH-1:0]      pwm_lvl,
    output logic [NCH-1:0]      pwm_oe
);
    typedef struct packed {
        logic       det;
        logic [2:0] n;
    } det_t;

    det_t cur_q, nxt_d;

    logic [NCH-1:0][CW-1:0] lc;
    logic [NCH-1:0][DW-1:0] duty_tgt;
    logic [NCH-1:0][IW-1:0] samp;

    always_comb begin
        nxt_d = cur_q;
        if (!cur_q.det) begin
            nxt_d.det = 1'b1;
            if (strap_sense == 2'b11)  nxt_d.n = 3'd2;
            else if (strap_sense[1])   nxt_d.n = 3'd3;
            else                       nxt_d.n = 3'd4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{det: 1'b0, n: 3'd4};
        else        cur_q <= nxt_d;
    end

    mpwm_phase_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cur_q.det),
        .n_ch  (cur_q.n),
        .lc    (lc)
    );

    mpwm_trim #(.PERIOD(PERIOD), .DW(DW), .IW(IW), .CORR_SHIFT(CORR_SHIFT)) u_trim (
        .n_ch     (cur_q.n),
        .duty_cmd (duty_cmd),
        .samp     (samp),
        .duty_tgt (duty_tgt)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic run_k;
        assign run_k = cur_q.det && (3'(k) < cur_q.n);
        mpwm_channel #(.PERIOD(PERIOD), .CW(CW), .DW(DW), .IW(IW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_k),
            .tristate  (tristate_req),
            .force_low (force_low_req),
            .lc        (lc[k]),
            .duty_tgt  (duty_tgt[k]),
            .isample   (isample[k*IW +: IW]),
            .lvl       (pwm_lvl[k]),
            .oe        (pwm_oe[k]),
            .samp_out  (samp[k])
        );
    end

    AST_NO_OE_BEFORE_DET: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.det |-> (pwm_oe == '0)); // R1
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.det |=> (cur_q.det && $stable(cur_q.n))); // R3
    AST_OE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwm_oe) <= int'(cur_q.n)); // R3
endmodule

// File: tb/mphase_pwm_tb.sv
module mphase_pwm_tb;
    localparam int P  = 24;
    localparam int IW = 8;
    localparam int SH = 1;
    localparam int DW = $clog2(P + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DW-1:0]   duty_cmd = '0;
    logic [4*IW-1:0] isample = '0;
    logic [1:0]      strap_sense = 2'b00;
    logic            tristate_req = 1'b0;
    logic            force_low_req = 1'b0;
    logic [3:0]      pwm_lvl, pwm_oe;

    always #10 clk = ~clk;

    mphase_pwm #(.PERIOD(P), .IW(IW), .CORR_SHIFT(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .isample(isample),
        .strap_sense(strap_sense), .tristate_req(tristate_req),
        .force_low_req(force_low_req), .pwm_lvl(pwm_lvl), .pwm_oe(pwm_oe)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    // bench-side stimulus values, applied at the falling edge
    int b_rst = 0, b_duty = 0, b_sense = 0, b_ts = 0, b_fl = 0;
    int b_is[4] = '{0, 0, 0, 0};

    // reference state
    int m_det = 0, m_n = 4, m_cnt = 0;
    int m_duty[4] = '{0, 0, 0, 0};
    int m_samp[4] = '{0, 0, 0, 0};

    function automatic int loc(int k);
        return (m_cnt + P - ((k * P / m_n) % P)) % P;
    endfunction

    function automatic int target(int k);
        int s = 0, a, c;
        for (int j = 0; j < m_n; j++) s += m_samp[j];
        a = s / m_n;
        c = b_duty + ((a - m_samp[k]) >>> SH);
        if (c < 0) c = 0;
        if (c > P) c = P;
        return c;
    endfunction

    task automatic model_step();
        int nd[4];
        int ns[4];
        if (b_rst == 0) begin
            m_det = 0; m_n = 4; m_cnt = 0;
            for (int k = 0; k < 4; k++) begin m_duty[k] = 0; m_samp[k] = 0; end
        end else if (m_det == 0) begin
            m_det = 1;
            m_n = (b_sense == 3) ? 2 : ((b_sense & 2) != 0 ? 3 : 4);
        end else begin
            for (int k = 0; k < 4; k++) begin
                nd[k] = m_duty[k]; ns[k] = m_samp[k];
                if (k < m_n) begin
                    if (loc(k) == (m_duty[k] + P / 3) % P) ns[k] = b_is[k];
                    if (loc(k) == P - 1) nd[k] = target(k);
                end
            end
            for (int k = 0; k < 4; k++) begin m_duty[k] = nd[k]; m_samp[k] = ns[k]; end
            m_cnt = (m_cnt + 1) % P;
        end
    endtask

    task automatic tick(input string tag);
        logic [3:0] el, eo;
        @(negedge clk);
        rst_n = (b_rst != 0);
        duty_cmd = DW'(b_duty);
        strap_sense = 2'(b_sense);
        tristate_req = (b_ts != 0);
        force_low_req = (b_fl != 0);
        for (int k = 0; k < 4; k++) isample[k*IW +: IW] = IW'(b_is[k]);
        #2;
        for (int k = 0; k < 4; k++) begin
            bit run = (b_rst != 0) && m_det != 0 && k < m_n;
            eo[k] = run && (b_fl != 0 || b_ts == 0);
            el[k] = eo[k] && b_fl == 0 && loc(k) < m_duty[k];
        end
        vecs++;
        if (pwm_lvl !== el || pwm_oe !== eo) begin
            errs++;
            $display("FAIL %s: lvl=%b oe=%b expected lvl=%b oe=%b", tag, pwm_lvl, pwm_oe, el, eo);
        end
        model_step();
    endtask

    task automatic check_oe_pattern(input int n, input string tag);
        logic [3:0] exp;
        exp = (n == 2) ? 4'b0011 : (n == 3) ? 4'b0111 : 4'b1111;
        vecs++;
        if (pwm_oe !== exp) begin
            errs++;
            $display("FAIL %s: oe=%b expected %b", tag, pwm_oe, exp);
        end
    endtask

    task automatic start(input int sense, input int n);
        b_rst = 0; b_ts = 0; b_fl = 0; b_sense = sense;
        repeat (3) tick("R1 reset outputs off");
        b_rst = 1;
        tick("R1 first cycle after release");
        b_sense = 3 - sense;
        tick("R2 R3 count decode");
        check_oe_pattern(n, "R2 active pattern");
    endtask

    task automatic random_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            if ($urandom % 40 == 0) b_duty = int'($urandom % 32);
            for (int k = 0; k < 4; k++) b_is[k] = 100 + k * 10 + int'($urandom % 40);
            b_ts = ($urandom % 30 == 0) ? 1 : 0;
            b_fl = ($urandom % 35 == 0) ? 1 : 0;
            if ($urandom % 50 == 0) b_sense = int'($urandom % 4);
            tick("R3 R4 R5 R6 R7 R9 R10 R11 random");
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        // four channels, both straps low
        start(0, 4);
        random_run(1500);
        // three channels, output 4 strapped
        start(2, 3);
        random_run(1500);
        // two channels, outputs 3 and 4 strapped
        start(3, 2);
        random_run(1500);
        // upper clamp: channel 0 far below the others
        b_ts = 0; b_fl = 0; b_duty = 31;
        b_is = '{0, 255, 255, 255};
        start(0, 4);
        repeat (200) tick("R8 upper clamp");
        // lower clamp: channel 0 far above the others
        b_duty = 0; b_is = '{255, 0, 0, 0};
        repeat (200) tick("R8 lower clamp");
        // boundary load with fixed unbalanced currents
        b_is = '{40, 120, 80, 160};
        for (int i = 0; i < 300; i++) begin
            if (i % 17 == 0) b_duty = 6 + (i % 13);
            tick("R6 R7 R9 boundary load");
        end
        // both requests together: force-low wins
        b_ts = 1; b_fl = 1;
        repeat (30) tick("R11 force-low priority");
        b_fl = 0;
        repeat (30) tick("R10 three-state");
        b_ts = 0;
        repeat (60) tick("R4 R5 resume");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule